// File: doc/BRIEF.md
# Multi-Master I2C Clock Synchronizer and Arbitration Monitor

This block is the bus-access core of an I2C master that shares open-drain SCL and SDA wires with other masters. It produces SCL from programmable low and high period counts, measured in system clocks. All timing decisions are taken from the synchronized level of the wired-AND bus, never from the block's own drive. As a result, a master with a longer low period stretches the shared clock, and a master whose high period ends first shortens it for everyone.

While it is master, the block drives SDA low whenever the serial bit to send is 0. At the sampling point just after each SCL rise it compares the bus against that bit. If it sent a 1 and sees SDA low, arbitration is lost. The block then drops every drive at once and falls back to slave-receive mode without creating a STOP, and it sets a sticky flag that stays set until it is cleared.

Byte framing, acknowledge handling, START and STOP generation and register access belong to surrounding logic. That logic supplies the bit to send, uses the bit strobe to advance, and issues start requests.

Top module: `i2c_sync_arb`

## Requirements
- R1: After reset, sclOe, sdaOe, bitStrobe, lostArb and masterMode are all 0.
- R2: Once started, the block drives SCL low (sclOe=1) for exactly lowCnt system clocks at each low phase; a lowCnt of 0 behaves as 1.
- R3: If no other device holds SCL, each released interval (sclOe=0) lasts highCnt+3 clocks: two synchronizer stages, one edge-detect cycle, then the high count. A highCnt of 0 behaves as 1.
- R4: If another device keeps SCL low for X clocks from the start of a low phase, with X greater than lowCnt, the block does not count high time while the bus stays low. The released interval then lasts X-lowCnt+highCnt+3 clocks. If X is not greater than lowCnt, the interval is unchanged.
- R5: A falling edge on the SCL bus during the high phase, caused by another device, ends the high phase. sclOe becomes 1 on the third clock edge after the bus falls.
- R6: bitStrobe is a single-cycle pulse in the cycle after the SCL rise is detected. On a free bus this is 3 clocks after sclOe is released.
- R7: While masterMode is 1, sdaOe equals the inverse of txBit (0 is driven low, 1 is released).
- R8: If txBit is 1 and SDA is sampled low during the bitStrobe cycle, then on the next clock masterMode goes to 0, lostArb goes to 1, and sclOe and sdaOe are 0.
- R9: After arbitration is lost, sclOe and sdaOe stay 0 until a new startReq arrives, so no STOP is produced.
- R10: lostArb stays 1 until a clrLost pulse. A new startReq does not clear it.
- R11: lowCnt and highCnt are captured only when a startReq is accepted. Later changes have no effect on the running clock.
- R12: No loss is reported if txBit is 0 with SDA low, or if txBit is 1 with SDA high. masterMode stays 1 and lostArb stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw SCL bus level |
| sdaIn | input | 1 | Raw SDA bus level |
| startReq | input | 1 | Begin acting as master; accepted only when not master |
| txBit | input | 1 | Serial bit to place on SDA |
| lowCnt | input | 8 | SCL low period in system clocks |
| highCnt | input | 8 | SCL high period in system clocks |
| clrLost | input | 1 | Clears the lost-arbitration flag |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |
| bitStrobe | output | 1 | One-cycle pulse at the SDA sampling point |
| lostArb | output | 1 | Sticky lost-arbitration flag |
| masterMode | output | 1 | 1 while master, 0 while slave-receive or idle |

## Verification
Two situations are hardest to reach from the ports: a second master that stretches the low phase, and a second master that cuts the high phase short. Neither shows up unless something else is pulling on the wired-AND bus. The bench therefore models a competing device that watches sclOe, grabs SCL for a chosen number of clocks at every low phase, and can also pull SCL or SDA low at a chosen moment. Arbitration loss is triggered by holding SDA low through a bit strobe while txBit is 1. The bench then watches the drive outputs across many clocks for any stray STOP-like activity.

// File: rtl/i2c_sync_arb_pkg.sv
package i2c_sync_arb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_LOW   = 2'd1,
    PH_HWAIT = 2'd2,
    PH_HIGH  = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLim;   // capture period counts
    logic cntClr;    // restart period counter
    logic useHigh;   // compare against high limit
    logic setLost;   // raise the sticky loss flag
  } dpCtl_t;

endpackage

// File: rtl/i2c_sync_arb_dp.sv
module i2c_sync_arb_dp
  import i2c_sync_arb_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic             clrLost,
  input  dpCtl_t           ctl,
  output logic             sdaS,
  output logic             sclRise,
  output logic             sclFall,
  output logic             arbSample,
  output logic             cntDone,
  output logic             lostArb
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] atLeastOne(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  logic [SYNC_DEPTH-1:0] sclPipe, sdaPipe;
  logic                  sclS, sclPrev;
  logic [CNT_W-1:0]      lowLim, highLim, cntQ, curLim;
  logic                  lostQ;

  // bus synchronizers, idle level is high
  for (genvar g = 0; g < SYNC_DEPTH; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[0] <= 1'b1;
          sdaPipe[0] <= 1'b1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe[g] <= 1'b1;
          sdaPipe[g] <= 1'b1;
        end else begin
          sclPipe[g] <= sclPipe[g-1];
          sdaPipe[g] <= sdaPipe[g-1];
        end
      end
    end
  end

  assign sclS = sclPipe[SYNC_DEPTH-1];
  assign sdaS = sdaPipe[SYNC_DEPTH-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev   <= 1'b1;
      arbSample <= 1'b0;
    end else begin
      sclPrev   <= sclS;
      arbSample <= sclRise;
    end
  end

  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;

  // period limits, captured at start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowLim  <= ONE;
      highLim <= ONE;
    end else if (ctl.loadLim) begin
      lowLim  <= atLeastOne(lowCnt);
      highLim <= atLeastOne(highCnt);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (ctl.cntClr)  cntQ <= '0;
    else                  cntQ <= cntQ + ONE;
  end

  assign curLim  = ctl.useHigh ? highLim : lowLim;
  assign cntDone = (cntQ == curLim - ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lostQ <= 1'b0;
    else if (ctl.setLost) lostQ <= 1'b1;
    else if (clrLost)     lostQ <= 1'b0;
  end

  assign lostArb = lostQ;

  // R10: flag holds until cleared
  a_r10_lost_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (lostQ && !clrLost) |=> lostQ);

  // R11: limits move only on a capture strobe
  a_r11_limits_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadLim |=> ($stable(lowLim) && $stable(highLim)));

  // R2: low-phase counter never passes its limit
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.cntClr && !ctl.useHigh) |-> (cntQ < lowLim));

  // R6: the sample point is a single-cycle pulse
  a_r6_sample_pulse: assert property (@(posedge clk) disable iff (!rstN)
    arbSample |=> !arbSample);

endmodule

// File: rtl/i2c_sync_arb_ctrl.sv
module i2c_sync_arb_ctrl
  import i2c_sync_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   txBit,
  input  logic   sdaS,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   arbSample,
  input  logic   cntDone,
  output dpCtl_t ctl,
  output logic   sclOe,
  output logic   sdaOe,
  output logic   bitStrobe,
  output logic   masterMode
);

  phase_t phase, phaseNext;
  logic   masterQ, masterNext;
  logic   lostNow;

  assign bitStrobe = arbSample && (phase == PH_HIGH);
  assign lostNow   = bitStrobe && masterQ && txBit && !sdaS;

  always_comb begin
    phaseNext  = phase;
    masterNext = masterQ;
    ctl        = '0;
    unique case (phase)
      PH_IDLE: begin
        ctl.cntClr = 1'b1;
        if (startReq) begin
          ctl.loadLim = 1'b1;
          masterNext  = 1'b1;
          phaseNext   = PH_LOW;
        end
      end
      PH_LOW: begin
        if (cntDone) begin
          ctl.cntClr = 1'b1;
          phaseNext  = PH_HWAIT;
        end
      end
      PH_HWAIT: begin
        ctl.cntClr = 1'b1;
        if (sclRise) phaseNext = PH_HIGH;
      end
      PH_HIGH: begin
        ctl.useHigh = 1'b1;
        if (lostNow) begin
          ctl.setLost = 1'b1;
          ctl.cntClr  = 1'b1;
          masterNext  = 1'b0;
          phaseNext   = PH_IDLE;
        end else if (sclFall || cntDone) begin
          ctl.cntClr = 1'b1;
          phaseNext  = PH_LOW;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      masterQ <= 1'b0;
    end else begin
      phase   <= phaseNext;
      masterQ <= masterNext;
    end
  end

  assign sclOe      = (phase == PH_LOW);
  assign sdaOe      = masterQ && !txBit;
  assign masterMode = masterQ;

  // R3: high counting starts only after an observed rise
  a_r3_high_after_rise: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_HIGH && $past(phase) != PH_HIGH) |-> $past(sclRise));

  // R8: a mismatch at the sample point leaves master mode
  a_r8_loss_exits: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && txBit && !sdaS) |=> (!masterQ && phase == PH_IDLE));

  // R9: no clock drive while not master unless restarted
  a_r9_quiet_slave: assert property (@(posedge clk) disable iff (!rstN)
    (!masterQ && !startReq) |=> !sclOe);

endmodule

// File: rtl/i2c_sync_arb.sv
module i2c_sync_arb
  import i2c_sync_arb_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             startReq,
  input  logic             txBit,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic             clrLost,
  output logic             sclOe,
  output logic             sdaOe,
  output logic             bitStrobe,
  output logic             lostArb,
  output logic             masterMode
);

  dpCtl_t ctl;
  logic   sdaS, sclRise, sclFall, arbSample, cntDone;

  i2c_sync_arb_dp #(
    .CNT_W     (CNT_W),
    .SYNC_DEPTH(SYNC_DEPTH)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .lowCnt   (lowCnt),
    .highCnt  (highCnt),
    .clrLost  (clrLost),
    .ctl      (ctl),
    .sdaS     (sdaS),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .arbSample(arbSample),
    .cntDone  (cntDone),
    .lostArb  (lostArb)
  );

  i2c_sync_arb_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .txBit     (txBit),
    .sdaS      (sdaS),
    .sclRise   (sclRise),
    .sclFall   (sclFall),
    .arbSample (arbSample),
    .cntDone   (cntDone),
    .ctl       (ctl),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe),
    .bitStrobe (bitStrobe),
    .masterMode(masterMode)
  );

  // R8: the datapath flag follows a control-detected mismatch
  a_r8_flag_raised: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && masterMode && txBit && !sdaS) |=> lostArb);

  // R7: SDA drive never appears outside master mode
  a_r7_sda_master_only: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> masterMode);

endmodule

// File: tb/i2c_sync_arb_tb.sv
`timescale 1ns/1ps
module i2c_sync_arb_tb_top;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN, startReq, txBit, clrLost;
  logic [7:0] lowCnt, highCnt;
  logic       sclOe, sdaOe, bitStrobe, lostArb, masterMode;
  logic       otherScl, manualScl, otherSda, prevOe;
  int         xLow, otherCnt;
  logic       sclBus, sdaBus;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  assign sclBus = !(sclOe | otherScl | manualScl);
  assign sdaBus = !(sdaOe | otherSda);

  i2c_sync_arb dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclBus), .sdaIn(sdaBus),
    .startReq(startReq), .txBit(txBit), .lowCnt(lowCnt), .highCnt(highCnt),
    .clrLost(clrLost), .sclOe(sclOe), .sdaOe(sdaOe), .bitStrobe(bitStrobe),
    .lostArb(lostArb), .masterMode(masterMode)
  );

  // competing master: grabs SCL for xLow clocks at each low phase
  always @(negedge clk) begin
    if (xLow > 0 && sclOe && !prevOe) begin
      otherScl = 1'b1;
      otherCnt = xLow - 1;
    end else if (otherCnt > 0) begin
      otherCnt = otherCnt - 1;
    end else begin
      otherScl = 1'b0;
    end
    prevOe = sclOe;
  end

  // columns: lowCnt, highCnt, competitor low, expected low width, expected released width
  localparam int NVEC = 6;
  localparam int VEC [NVEC][5] = '{
    '{4, 5, 0, 4, 8},
    '{0, 0, 0, 1, 4},
    '{10, 2, 0, 10, 5},
    '{3, 4, 8, 3, 12},
    '{6, 2, 4, 6, 5},
    '{20, 1, 30, 20, 14}
  };

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; startReq = 1'b0; txBit = 1'b1; clrLost = 1'b0;
    lowCnt = 8'd4; highCnt = 8'd4; xLow = 0; manualScl = 1'b0; otherSda = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startMaster(input int lo, input int hi);
    lowCnt = 8'(lo); highCnt = 8'(hi);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic measure(output int lowW, output int relW);
    while (sclOe) @(negedge clk);
    while (!sclOe) @(negedge clk);
    lowW = 0; relW = 0;
    while (sclOe) begin lowW++; @(negedge clk); end
    while (!sclOe) begin relW++; @(negedge clk); end
  endtask

  task automatic waitStrobe();
    do @(negedge clk); while (!bitStrobe);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lw, rw, n, bad;
    otherScl = 1'b0; otherCnt = 0; prevOe = 1'b0;
    doReset();
    // R1 reset state
    check("R1 reset sclOe", sclOe, 0);
    check("R1 reset sdaOe", sdaOe, 0);
    check("R1 reset strobe/lost/master", {bitStrobe, lostArb, masterMode}, 0);

    // R2 R3 R4: period table
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      xLow = VEC[v][2];
      startMaster(VEC[v][0], VEC[v][1]);
      measure(lw, rw);
      check($sformatf("R2 low width vec%0d", v), lw, VEC[v][3]);
      check($sformatf("R3/R4 released width vec%0d", v), rw, VEC[v][4]);
    end

    // R11: counts changed after start are ignored
    doReset();
    startMaster(5, 3);
    lowCnt = 8'd40; highCnt = 8'd40;
    measure(lw, rw);
    check("R11 low width keeps captured count", lw, 5);
    check("R11 released width keeps captured count", rw, 6);

    // R6: strobe timing and width
    doReset();
    startMaster(4, 5);
    while (!sclOe) @(negedge clk);
    while (sclOe) @(negedge clk);
    n = 0;
    while (!bitStrobe) begin @(negedge clk); n++; end
    check("R6 strobe delay after release", n, 3);
    @(negedge clk);
    check("R6 strobe is one cycle", bitStrobe, 0);

    // R5: competitor pulls SCL low during high phase
    doReset();
    startMaster(4, 20);
    waitStrobe();
    manualScl = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R5 no drive two edges after fall", sclOe, 0);
    @(negedge clk);
    check("R5 drive on third edge after fall", sclOe, 1);
    repeat (10) @(negedge clk);
    manualScl = 1'b0;

    // R7 R12: txBit 0 with SDA low, no loss
    doReset();
    txBit = 1'b0;
    startMaster(3, 4);
    check("R7 sdaOe follows txBit=0", sdaOe, 1);
    waitStrobe();
    @(negedge clk);
    check("R12 txBit 0 keeps master", masterMode, 1);
    check("R12 txBit 0 no loss flag", lostArb, 0);
    txBit = 1'b1;
    #0;
    check("R7 sdaOe released for txBit=1", sdaOe, 0);

    // R8 R9 R10: lost arbitration
    doReset();
    otherSda = 1'b1;
    txBit = 1'b1;
    startMaster(3, 4);
    waitStrobe();
    @(negedge clk);
    check("R8 loss sets flag", lostArb, 1);
    check("R8 loss leaves master", masterMode, 0);
    check("R8 loss drops drives", {sclOe, sdaOe}, 0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclOe || sdaOe) bad++;
    end
    check("R9 no drive after loss", bad, 0);
    otherSda = 1'b0;
    repeat (20) @(negedge clk);
    check("R10 flag stays set", lostArb, 1);
    startMaster(3, 4);
    check("R10 restart keeps flag", {masterMode, lostArb}, 3);
    clrLost = 1'b1;
    @(negedge clk);
    clrLost = 1'b0;
    check("R10 clear drops flag", lostArb, 0);

    // R12: txBit 1 with SDA high, no loss
    waitStrobe();
    @(negedge clk);
    check("R12 matching 1 keeps master", masterMode, 1);
    check("R12 matching 1 no loss flag", lostArb, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule